// File: doc/BRIEF.md
# PDM Microphone Capture Register Block

This block is the software-visible control and status register file of an eight-channel PDM microphone capture engine. A bus master reaches it through a simple word-addressed port. Writes take effect at the next clock edge. Read data is combinational on the address. The block has two jobs toward the datapath:

- It drives the engine's configuration out as plain fields: channel enables, interface enable, disable, clock divider, oversampling, quality, per-channel gain, FIFO watermark and DC-remover mode.
- It gathers single-cycle event pulses from the datapath into sticky flags. Software clears these flags by writing ones to them.

A two-bit request-select field decides how pending channel data is signalled. It can raise a DMA request, raise an interrupt, or raise neither. A separate error interrupt follows the low-clock-frequency flag.

The block also has a soft-reset command bit. It pulses for exactly one cycle, always reads as zero, and clears the channel data-ready flags only while the disable bit is low. Detector configuration and status words are kept as storage only, so that software sees the reset values it expects.

Top module: `pdm_csr_regs`

## Requirements
- R1: Registers are 32 bits wide and sit on a 4-byte stride. A write to an undefined or misaligned address changes nothing. A read from such an address returns 0.
- R2: After reset, the following registers hold these values, and every other register reads 0:
  - FIFO config (0x0C) reads 0x00000007.
  - Detector config 2 (0x24) reads 0x000A0000.
  - Detector noise config (0x2C) reads 0x80000000.
  - Detector zero-cross config (0x30) reads 0x00000004.
- R3: Writing 1 to bit 10 of control A (0x00) raises `soft_rst_o` for exactly the one following cycle. That bit always reads back as 0.
- R4: In the cycle after the soft-reset pulse, the channel data-ready flags (status 0x08, bits 7:0) are cleared, but only if the disable bit (control A bit 9) is 0. If the disable bit is 1, the flags are kept.
- R5: Request-select is control A bits 13:12. The value 01 drives `dma_req_o` and 10 drives `irq_o`. The values 00 and 11 drive neither. The selected output is high while any channel has both its data-ready flag and its enable (control A bits 7:0) set.
- R6: The four status words are write-1-to-clear: status 0x08, FIFO status 0x10, output status 0x1C and detector status 0x28. In each, writing 1 clears that bit and writing 0 leaves it unchanged.
- R7: Channel n's data word is read at 0x40+4n from lane n of `ch_data_i`. Writes to these addresses have no effect.
- R8: When a flag's set pulse and a write-1 clear of that flag arrive in the same cycle, the flag ends up set.
- R9: The gain word (0x14) holds channel n's gain at bits 4n+3:4n and drives `gain_o` in the same layout. Control A drives `ch_en_o` from bits 7:0 and `iface_en_o` from bit 8.
- R10: The low-frequency flag is status bit 16. `err_irq_o` equals that flag, whatever request-select holds.
- R11: In FIFO status, channel n's overflow flag is bit n and its underflow flag is bit 8+n.
- R12: Control B (0x04) stores:
  - the clock divider in bits 7:0,
  - oversampling in bits 11:8,
  - quality in bits 14:12.

  FIFO config stores the watermark in bits 4:0. DC config (0x18) stores a 2-bit mode per channel at bits 2n+1:2n. Bits outside these fields read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe for the addressed word |
| addr_i | input | ADDR_W | Byte address for both read and write |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Combinational read data for addr_i |
| ready_set_i | input | NUM_CH | Per-channel data-ready event pulses |
| fifo_over_set_i | input | NUM_CH | Per-channel FIFO overflow event pulses |
| fifo_under_set_i | input | NUM_CH | Per-channel FIFO underflow event pulses |
| out_set_i | input | NUM_CH | Per-channel output status event pulses |
| det_set_i | input | 1 | Detector event pulse |
| low_freq_set_i | input | 1 | Low filter clock frequency event pulse |
| ch_data_i | input | NUM_CH*32 | Per-channel captured data words, channel n in bits 32n+31:32n |
| ch_en_o | output | NUM_CH | Channel enables |
| iface_en_o | output | 1 | Interface enable |
| mod_dis_o | output | 1 | Module disable |
| soft_rst_o | output | 1 | One-cycle soft reset pulse |
| clk_div_o | output | CLKDIV_W | Clock divider |
| osr_o | output | OSR_W | Oversampling setting |
| qsel_o | output | QSEL_W | Quality select |
| gain_o | output | NUM_CH*GAIN_W | Per-channel gain fields |
| dc_mode_o | output | NUM_CH*DC_W | Per-channel DC-remover mode |
| fifo_wmk_o | output | WMK_W | FIFO watermark |
| dma_req_o | output | 1 | DMA request |
| irq_o | output | 1 | Data interrupt |
| err_irq_o | output | 1 | Error interrupt (low frequency) |

## Verification
The bench builds the block with its default parameters: eight channels, 4-bit gains, 2-bit DC modes, an 8-bit address and a 5-bit watermark resetting to 7. With these, every field fills its full documented position, so the following can all be checked bit-exactly at the ports:
- the gain nibbles of all eight channels, including channel 7 at the top of the word;
- the highest channel data address, 0x5C;
- underflow bit 15.

Eight channels also let one channel's data-ready flag be raised while its enable is low. This shows that a disabled channel never requests service, and that the soft reset's clear covers every flag.

// File: rtl/pdm_csr_pkg.sv
package pdm_csr_pkg;

   // Byte offsets of the register words
   localparam logic [15:0] OFF_CTRL_A    = 16'h0000;
   localparam logic [15:0] OFF_CTRL_B    = 16'h0004;
   localparam logic [15:0] OFF_STAT      = 16'h0008;
   localparam logic [15:0] OFF_FIFO_CFG  = 16'h000C;
   localparam logic [15:0] OFF_FIFO_STAT = 16'h0010;
   localparam logic [15:0] OFF_GAIN      = 16'h0014;
   localparam logic [15:0] OFF_DC_CFG    = 16'h0018;
   localparam logic [15:0] OFF_OUT_STAT  = 16'h001C;
   localparam logic [15:0] OFF_DET_CFG1  = 16'h0020;
   localparam logic [15:0] OFF_DET_CFG2  = 16'h0024;
   localparam logic [15:0] OFF_DET_STAT  = 16'h0028;
   localparam logic [15:0] OFF_DET_NOISE = 16'h002C;
   localparam logic [15:0] OFF_DET_ZCD   = 16'h0030;
   localparam logic [15:0] OFF_CH_DATA   = 16'h0040;

   // Bit positions inside control A, control B and the status words
   localparam int CA_IFACE = 8;
   localparam int CA_DIS   = 9;
   localparam int CA_SRST  = 10;
   localparam int CA_REQ   = 12;
   localparam int CB_OSR   = 8;
   localparam int CB_QSEL  = 12;
   localparam int ST_LOWF  = 16;
   localparam int FS_UNDER = 8;

   localparam logic [31:0] RST_DET_CFG2  = 32'h000A_0000;
   localparam logic [31:0] RST_DET_NOISE = 32'h8000_0000;
   localparam logic [31:0] RST_DET_ZCD   = 32'h0000_0004;

   typedef enum logic [1:0] {
      REQ_OFF  = 2'b00,
      REQ_DMA  = 2'b01,
      REQ_IRQ  = 2'b10,
      REQ_RSVD = 2'b11
   } req_sel_e;

   function automatic logic [31:0] lowmask(input int n);
      if (n >= 32) return '1;
      return (32'd1 << n) - 32'd1;
   endfunction

endpackage

// File: rtl/pdm_csr_cfg.sv
module pdm_csr_cfg #(
   parameter logic [31:0] RST  = 32'h0,
   parameter logic [31:0] MASK = 32'hFFFF_FFFF
) (
   input  logic        clk_i,
   input  logic        rst_ni,
   input  logic        we_i,
   input  logic [31:0] wdata_i,
   output logic [31:0] q_o
);
   logic [31:0] store_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   store_q <= RST & MASK;
      else if (we_i) store_q <= wdata_i & MASK;
   end

   assign q_o = store_q;
endmodule

// File: rtl/pdm_csr_w1c.sv
module pdm_csr_w1c #(
   parameter int W = 32
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         we_i,
   input  logic [W-1:0] wdata_i,
   input  logic [W-1:0] set_i,
   input  logic [W-1:0] sclr_i,
   output logic [W-1:0] q_o
);
   logic [W-1:0] flag_q;
   logic [W-1:0] clr;

   assign clr = (we_i ? wdata_i : '0) | sclr_i;

   // A set pulse overrides any clear arriving in the same cycle
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flag_q <= '0;
      else         flag_q <= (flag_q & ~clr) | set_i;
   end

   assign q_o = flag_q;
endmodule

// File: rtl/pdm_csr_req.sv
module pdm_csr_req
   import pdm_csr_pkg::*;
#(
   parameter int NUM_CH = 8
) (
   input  logic [1:0]        req_sel_i,
   input  logic [NUM_CH-1:0] ready_i,
   input  logic [NUM_CH-1:0] en_i,
   input  logic              low_freq_i,
   output logic              dma_req_o,
   output logic              irq_o,
   output logic              err_irq_o
);
   logic [NUM_CH-1:0] pend;
   logic              any_pend;
   req_sel_e          sel;

   for (genvar n = 0; n < NUM_CH; n++) begin : g_pend
      assign pend[n] = ready_i[n] & en_i[n];
   end

   assign any_pend  = |pend;
   assign sel       = req_sel_e'(req_sel_i);
   assign dma_req_o = any_pend && (sel == REQ_DMA);
   assign irq_o     = any_pend && (sel == REQ_IRQ);
   assign err_irq_o = low_freq_i;
endmodule

// File: rtl/pdm_csr_regs.sv
module pdm_csr_regs
   import pdm_csr_pkg::*;
#(
   parameter int          NUM_CH   = 8,
   parameter int          ADDR_W   = 8,
   parameter int          GAIN_W   = 4,
   parameter int          DC_W     = 2,
   parameter int          CLKDIV_W = 8,
   parameter int          OSR_W    = 4,
   parameter int          QSEL_W   = 3,
   parameter int          WMK_W    = 5,
   parameter logic [31:0] WMK_RST  = 32'd7
) (
   input  logic                     clk_i,
   input  logic                     rst_ni,
   input  logic                     wr_en_i,
   input  logic [ADDR_W-1:0]        addr_i,
   input  logic [31:0]              wr_data_i,
   output logic [31:0]              rd_data_o,
   input  logic [NUM_CH-1:0]        ready_set_i,
   input  logic [NUM_CH-1:0]        fifo_over_set_i,
   input  logic [NUM_CH-1:0]        fifo_under_set_i,
   input  logic [NUM_CH-1:0]        out_set_i,
   input  logic                     det_set_i,
   input  logic                     low_freq_set_i,
   input  logic [NUM_CH*32-1:0]     ch_data_i,
   output logic [NUM_CH-1:0]        ch_en_o,
   output logic                     iface_en_o,
   output logic                     mod_dis_o,
   output logic                     soft_rst_o,
   output logic [CLKDIV_W-1:0]      clk_div_o,
   output logic [OSR_W-1:0]         osr_o,
   output logic [QSEL_W-1:0]        qsel_o,
   output logic [NUM_CH*GAIN_W-1:0] gain_o,
   output logic [NUM_CH*DC_W-1:0]   dc_mode_o,
   output logic [WMK_W-1:0]         fifo_wmk_o,
   output logic                     dma_req_o,
   output logic                     irq_o,
   output logic                     err_irq_o
);
   localparam logic [31:0] CH_MASK   = lowmask(NUM_CH);
   localparam logic [31:0] CA_MASK   = CH_MASK | (32'd1 << CA_IFACE) | (32'd1 << CA_DIS)
                                       | (32'd3 << CA_REQ);
   localparam logic [31:0] CB_MASK   = lowmask(CLKDIV_W) | (lowmask(OSR_W) << CB_OSR)
                                       | (lowmask(QSEL_W) << CB_QSEL);
   localparam logic [31:0] GAIN_MASK = lowmask(NUM_CH * GAIN_W);
   localparam logic [31:0] DC_MASK   = lowmask(NUM_CH * DC_W);
   localparam logic [31:0] WMK_MASK  = lowmask(WMK_W);

   // Elaboration-time parameter checks
   if (NUM_CH < 1 || NUM_CH > 8) begin : g_bad_ch
      $error("NUM_CH must be 1..8");
   end
   if (ADDR_W < 7 || ADDR_W > 16) begin : g_bad_addr
      $error("ADDR_W must be 7..16");
   end
   if (NUM_CH * GAIN_W > 32 || NUM_CH * DC_W > 32) begin : g_bad_fields
      $error("gain or DC fields exceed one word");
   end
   if (CLKDIV_W > 8 || OSR_W > 4 || QSEL_W > 4 || WMK_W > 32) begin : g_bad_cfg
      $error("control B or watermark field too wide");
   end

   logic [15:0] addr16;
   assign addr16 = 16'(addr_i);

   logic we_ca, we_cb, we_st, we_fc, we_fs, we_gn, we_dc, we_os;
   logic we_d1, we_d2, we_ds, we_dn, we_dz;
   assign we_ca = wr_en_i && addr16 == OFF_CTRL_A;
   assign we_cb = wr_en_i && addr16 == OFF_CTRL_B;
   assign we_st = wr_en_i && addr16 == OFF_STAT;
   assign we_fc = wr_en_i && addr16 == OFF_FIFO_CFG;
   assign we_fs = wr_en_i && addr16 == OFF_FIFO_STAT;
   assign we_gn = wr_en_i && addr16 == OFF_GAIN;
   assign we_dc = wr_en_i && addr16 == OFF_DC_CFG;
   assign we_os = wr_en_i && addr16 == OFF_OUT_STAT;
   assign we_d1 = wr_en_i && addr16 == OFF_DET_CFG1;
   assign we_d2 = wr_en_i && addr16 == OFF_DET_CFG2;
   assign we_ds = wr_en_i && addr16 == OFF_DET_STAT;
   assign we_dn = wr_en_i && addr16 == OFF_DET_NOISE;
   assign we_dz = wr_en_i && addr16 == OFF_DET_ZCD;

   logic [31:0] ca_q, cb_q, fc_q, gn_q, dc_q, d1_q, d2_q, dn_q, dz_q;
   logic [31:0] st_q, fs_q, os_q, ds_q;

   pdm_csr_cfg #(.RST(32'h0),         .MASK(CA_MASK))   u_ctrl_a (.clk_i, .rst_ni, .we_i(we_ca), .wdata_i(wr_data_i), .q_o(ca_q));
   pdm_csr_cfg #(.RST(32'h0),         .MASK(CB_MASK))   u_ctrl_b (.clk_i, .rst_ni, .we_i(we_cb), .wdata_i(wr_data_i), .q_o(cb_q));
   pdm_csr_cfg #(.RST(WMK_RST),       .MASK(WMK_MASK))  u_fifo_c (.clk_i, .rst_ni, .we_i(we_fc), .wdata_i(wr_data_i), .q_o(fc_q));
   pdm_csr_cfg #(.RST(32'h0),         .MASK(GAIN_MASK)) u_gain   (.clk_i, .rst_ni, .we_i(we_gn), .wdata_i(wr_data_i), .q_o(gn_q));
   pdm_csr_cfg #(.RST(32'h0),         .MASK(DC_MASK))   u_dc     (.clk_i, .rst_ni, .we_i(we_dc), .wdata_i(wr_data_i), .q_o(dc_q));
   pdm_csr_cfg #(.RST(32'h0))                           u_det1   (.clk_i, .rst_ni, .we_i(we_d1), .wdata_i(wr_data_i), .q_o(d1_q));
   pdm_csr_cfg #(.RST(RST_DET_CFG2))                    u_det2   (.clk_i, .rst_ni, .we_i(we_d2), .wdata_i(wr_data_i), .q_o(d2_q));
   pdm_csr_cfg #(.RST(RST_DET_NOISE))                   u_detn   (.clk_i, .rst_ni, .we_i(we_dn), .wdata_i(wr_data_i), .q_o(dn_q));
   pdm_csr_cfg #(.RST(RST_DET_ZCD))                     u_detz   (.clk_i, .rst_ni, .we_i(we_dz), .wdata_i(wr_data_i), .q_o(dz_q));

   // Soft reset: command bit is never stored, it only launches a one-cycle pulse
   logic srst_q, srst_act;
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) srst_q <= 1'b0;
      else         srst_q <= we_ca && wr_data_i[CA_SRST];
   end
   assign srst_act = srst_q && !ca_q[CA_DIS];

   logic [31:0] st_set, st_sclr, fs_set, os_set, ds_set;
   assign st_set  = 32'(ready_set_i) | (32'(low_freq_set_i) << ST_LOWF);
   assign st_sclr = srst_act ? CH_MASK : 32'h0;
   assign fs_set  = 32'(fifo_over_set_i) | (32'(fifo_under_set_i) << FS_UNDER);
   assign os_set  = 32'(out_set_i);
   assign ds_set  = 32'(det_set_i);

   pdm_csr_w1c #(.W(32)) u_stat  (.clk_i, .rst_ni, .we_i(we_st), .wdata_i(wr_data_i), .set_i(st_set), .sclr_i(st_sclr), .q_o(st_q));
   pdm_csr_w1c #(.W(32)) u_fstat (.clk_i, .rst_ni, .we_i(we_fs), .wdata_i(wr_data_i), .set_i(fs_set), .sclr_i(32'h0),   .q_o(fs_q));
   pdm_csr_w1c #(.W(32)) u_ostat (.clk_i, .rst_ni, .we_i(we_os), .wdata_i(wr_data_i), .set_i(os_set), .sclr_i(32'h0),   .q_o(os_q));
   pdm_csr_w1c #(.W(32)) u_dstat (.clk_i, .rst_ni, .we_i(we_ds), .wdata_i(wr_data_i), .set_i(ds_set), .sclr_i(32'h0),   .q_o(ds_q));

   logic [NUM_CH-1:0] ready_flags;
   assign ready_flags = st_q[NUM_CH-1:0];

   pdm_csr_req #(.NUM_CH(NUM_CH)) u_req (
      .req_sel_i (ca_q[CA_REQ +: 2]),
      .ready_i   (ready_flags),
      .en_i      (ca_q[NUM_CH-1:0]),
      .low_freq_i(st_q[ST_LOWF]),
      .dma_req_o (dma_req_o),
      .irq_o     (irq_o),
      .err_irq_o (err_irq_o)
   );

   // Per-channel data words, one address each
   logic [NUM_CH-1:0] ch_hit;
   logic [31:0]       ch_rd [NUM_CH];
   for (genvar n = 0; n < NUM_CH; n++) begin : g_chan
      assign ch_hit[n] = addr16 == (OFF_CH_DATA + 16'(4 * n));
      assign ch_rd[n]  = ch_data_i[n*32 +: 32];
   end

   always_comb begin
      rd_data_o = 32'h0;
      unique case (addr16)
         OFF_CTRL_A:    rd_data_o = ca_q;
         OFF_CTRL_B:    rd_data_o = cb_q;
         OFF_STAT:      rd_data_o = st_q;
         OFF_FIFO_CFG:  rd_data_o = fc_q;
         OFF_FIFO_STAT: rd_data_o = fs_q;
         OFF_GAIN:      rd_data_o = gn_q;
         OFF_DC_CFG:    rd_data_o = dc_q;
         OFF_OUT_STAT:  rd_data_o = os_q;
         OFF_DET_CFG1:  rd_data_o = d1_q;
         OFF_DET_CFG2:  rd_data_o = d2_q;
         OFF_DET_STAT:  rd_data_o = ds_q;
         OFF_DET_NOISE: rd_data_o = dn_q;
         OFF_DET_ZCD:   rd_data_o = dz_q;
         default: begin
            for (int n = 0; n < NUM_CH; n++)
               if (ch_hit[n]) rd_data_o = ch_rd[n];
         end
      endcase
   end

   assign ch_en_o    = ca_q[NUM_CH-1:0];
   assign iface_en_o = ca_q[CA_IFACE];
   assign mod_dis_o  = ca_q[CA_DIS];
   assign soft_rst_o = srst_q;
   assign clk_div_o  = cb_q[CLKDIV_W-1:0];
   assign osr_o      = cb_q[CB_OSR +: OSR_W];
   assign qsel_o     = cb_q[CB_QSEL +: QSEL_W];
   assign gain_o     = gn_q[NUM_CH*GAIN_W-1:0];
   assign dc_mode_o  = dc_q[NUM_CH*DC_W-1:0];
   assign fifo_wmk_o = fc_q[WMK_W-1:0];
endmodule

// File: rtl/pdm_csr_chk.sv
module pdm_csr_chk
   import pdm_csr_pkg::*;
#(
   parameter int NUM_CH = 8,
   parameter int ADDR_W = 8
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              wr_en_i,
   input logic [ADDR_W-1:0] addr_i,
   input logic [31:0]       wr_data_i,
   input logic [31:0]       rd_data_o,
   input logic              soft_rst_o,
   input logic              mod_dis_o,
   input logic [NUM_CH-1:0] ready_set_i,
   input logic [NUM_CH-1:0] ready_flags,
   input logic              low_freq_set_i,
   input logic              err_irq_o,
   input logic              dma_req_o,
   input logic              irq_o
);
   logic [15:0] a16;
   assign a16 = 16'(addr_i);

   AST_SRST_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (a16 == OFF_CTRL_A) |-> !rd_data_o[CA_SRST]);                                     // R3
   AST_SRST_FROM_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      soft_rst_o |-> $past(wr_en_i && a16 == OFF_CTRL_A && wr_data_i[CA_SRST]));        // R3
   AST_SRST_CLEARS_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (soft_rst_o && !mod_dis_o && ready_set_i == '0) |=> (ready_flags == '0));          // R4
   AST_DIS_KEEPS_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (soft_rst_o && mod_dis_o && !(wr_en_i && a16 == OFF_STAT))
      |=> ((ready_flags & $past(ready_flags)) == $past(ready_flags)));                   // R4
   AST_REQ_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(dma_req_o && irq_o));                                                            // R5
   AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      low_freq_set_i |=> err_irq_o);                                                     // R8
   AST_LOWF_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!low_freq_set_i && !(wr_en_i && a16 == OFF_STAT && wr_data_i[ST_LOWF]))
      |=> (err_irq_o == $past(err_irq_o)));                                              // R6
endmodule

bind pdm_csr_regs pdm_csr_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
   .clk_i         (clk_i),
   .rst_ni        (rst_ni),
   .wr_en_i       (wr_en_i),
   .addr_i        (addr_i),
   .wr_data_i     (wr_data_i),
   .rd_data_o     (rd_data_o),
   .soft_rst_o    (soft_rst_o),
   .mod_dis_o     (mod_dis_o),
   .ready_set_i   (ready_set_i),
   .ready_flags   (ready_flags),
   .low_freq_set_i(low_freq_set_i),
   .err_irq_o     (err_irq_o),
   .dma_req_o     (dma_req_o),
   .irq_o         (irq_o)
);

// File: tb/pdm_csr_regs_tb_top.sv
`timescale 1ns/1ps
module pdm_csr_regs_tb_top;
   localparam int NCH = 8;
   localparam int AW  = 8;

   logic              clk_i = 1'b0;
   logic              rst_ni = 1'b0;
   logic              wr_en_i = 1'b0;
   logic [AW-1:0]     addr_i = '0;
   logic [31:0]       wr_data_i = '0;
   logic [31:0]       rd_data_o;
   logic [NCH-1:0]    ready_set_i = '0, fifo_over_set_i = '0, fifo_under_set_i = '0, out_set_i = '0;
   logic              det_set_i = 1'b0, low_freq_set_i = 1'b0;
   logic [NCH*32-1:0] ch_data_i;
   logic [NCH-1:0]    ch_en_o;
   logic              iface_en_o, mod_dis_o, soft_rst_o;
   logic [7:0]        clk_div_o;
   logic [3:0]        osr_o;
   logic [2:0]        qsel_o;
   logic [NCH*4-1:0]  gain_o;
   logic [NCH*2-1:0]  dc_mode_o;
   logic [4:0]        fifo_wmk_o;
   logic              dma_req_o, irq_o, err_irq_o;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #2 clk_i = ~clk_i;

   for (genvar n = 0; n < NCH; n++) begin : g_data
      assign ch_data_i[n*32 +: 32] = 32'hC0DE_0000 + 32'(n * 32'h111);
   end

   pdm_csr_regs dut_i (.*);

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk_i);
      wr_en_i = 1'b1; addr_i = a; wr_data_i = d;
      @(negedge clk_i);
      wr_en_i = 1'b0;
   endtask

   task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
      addr_i = a;
      #1;
      chk(req, rd_data_o, exp);
   endtask

   // Table: [76:73] requirement, [72] write, [71:64] addr, [63:32] wdata, [31:0] expected read
   localparam int NV = 14;
   localparam logic [76:0] VEC [NV] = '{
      {4'd12, 1'b1, 8'h04, 32'hFFFF_FFFF, 32'h0},
      {4'd12, 1'b0, 8'h04, 32'h0,         32'h0000_7FFF},   // R12 control B fields
      {4'd9,  1'b1, 8'h14, 32'h1234_5678, 32'h0},
      {4'd9,  1'b0, 8'h14, 32'h0,         32'h1234_5678},   // R9 gain word
      {4'd12, 1'b1, 8'h18, 32'hFFFF_FFFF, 32'h0},
      {4'd12, 1'b0, 8'h18, 32'h0,         32'h0000_FFFF},   // R12 DC modes
      {4'd12, 1'b1, 8'h0C, 32'hFFFF_FFFF, 32'h0},
      {4'd12, 1'b0, 8'h0C, 32'h0,         32'h0000_001F},   // R12 watermark
      {4'd1,  1'b1, 8'h3C, 32'hDEAD_BEEF, 32'h0},
      {4'd1,  1'b0, 8'h3C, 32'h0,         32'h0},           // R1 undefined offset
      {4'd1,  1'b1, 8'h16, 32'hFFFF_FFFF, 32'h0},
      {4'd1,  1'b0, 8'h14, 32'h0,         32'h1234_5678},   // R1 misaligned write ignored
      {4'd1,  1'b0, 8'h15, 32'h0,         32'h0},           // R1 misaligned read
      {4'd2,  1'b0, 8'h24, 32'h0,         32'h000A_0000}    // R2 still at reset value
   };

   initial begin : watchdog
      repeat (20000) @(posedge clk_i);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin : main
      repeat (5) @(negedge clk_i);
      rst_ni = 1'b1;
      @(negedge clk_i);

      // R2 reset values
      rd_chk("R2", 8'h00, 32'h0);
      rd_chk("R2", 8'h04, 32'h0);
      rd_chk("R2", 8'h08, 32'h0);
      rd_chk("R2", 8'h0C, 32'h7);
      rd_chk("R2", 8'h10, 32'h0);
      rd_chk("R2", 8'h14, 32'h0);
      rd_chk("R2", 8'h18, 32'h0);
      rd_chk("R2", 8'h1C, 32'h0);
      rd_chk("R2", 8'h20, 32'h0);
      rd_chk("R2", 8'h24, 32'h000A_0000);
      rd_chk("R2", 8'h28, 32'h0);
      rd_chk("R2", 8'h2C, 32'h8000_0000);
      rd_chk("R2", 8'h30, 32'h4);
      chk("R5 reset", {29'h0, dma_req_o, irq_o, err_irq_o}, 32'h0);
      chk("R3 reset", 32'(soft_rst_o), 32'h0);

      for (int i = 0; i < NV; i++) begin
         if (VEC[i][72]) wr(VEC[i][71:64], VEC[i][63:32]);
         else begin
            @(negedge clk_i);
            addr_i = VEC[i][71:64];
            #1;
            checks++;
            if (rd_data_o !== VEC[i][31:0]) begin
               errors++;
               $display("FAIL R%0d table entry %0d: actual=%08h expected=%08h",
                        VEC[i][76:73], i, rd_data_o, VEC[i][31:0]);
            end
         end
      end

      // R9 gain slices and channel enables
      for (int n = 0; n < NCH; n++) chk("R9 gain", 32'(gain_o[n*4 +: 4]), 32'(8 - n));
      wr(8'h00, 32'h0000_01A5);
      chk("R9 ch_en", 32'(ch_en_o), 32'hA5);
      chk("R9 iface", 32'(iface_en_o), 32'h1);
      chk("R12 outputs", {clk_div_o, osr_o, 1'b0, qsel_o, fifo_wmk_o, 11'h0}, 32'hFF_F7_F8_00);

      // R7 channel data read-only
      for (int n = 0; n < NCH; n++)
         rd_chk("R7", 8'(8'h40 + 4 * n), 32'hC0DE_0000 + 32'(n * 32'h111));
      wr(8'h44, 32'h0);
      rd_chk("R7 write ignored", 8'h44, 32'hC0DE_0111);

      // R11 / R6 FIFO status
      @(negedge clk_i); fifo_over_set_i = 8'h04; fifo_under_set_i = 8'h20;
      @(negedge clk_i); fifo_over_set_i = '0;    fifo_under_set_i = '0;
      rd_chk("R11", 8'h10, 32'h0000_2004);
      wr(8'h10, 32'h0);
      rd_chk("R6 write 0", 8'h10, 32'h0000_2004);
      wr(8'h10, 32'h0000_0004);
      rd_chk("R6 write 1", 8'h10, 32'h0000_2000);
      wr(8'h10, 32'hFFFF_FFFF);
      rd_chk("R6 clear all", 8'h10, 32'h0);
      @(negedge clk_i); out_set_i = 8'h02; det_set_i = 1'b1;
      @(negedge clk_i); out_set_i = '0;    det_set_i = 1'b0;
      rd_chk("R6 out stat", 8'h1C, 32'h2);
      rd_chk("R6 det stat", 8'h28, 32'h1);
      wr(8'h1C, 32'h2);
      wr(8'h28, 32'h1);
      rd_chk("R6 out clr", 8'h1C, 32'h0);
      rd_chk("R6 det clr", 8'h28, 32'h0);

      // R5 request routing
      wr(8'h00, 32'h0000_1001);
      @(negedge clk_i); ready_set_i = 8'h08;
      @(negedge clk_i); ready_set_i = '0;
      chk("R5 disabled ch", {30'h0, dma_req_o, irq_o}, 32'h0);
      @(negedge clk_i); ready_set_i = 8'h01;
      @(negedge clk_i); ready_set_i = '0;
      chk("R5 dma", {30'h0, dma_req_o, irq_o}, 32'h2);
      wr(8'h00, 32'h0000_2001);
      chk("R5 irq", {30'h0, dma_req_o, irq_o}, 32'h1);
      wr(8'h00, 32'h0000_3001);
      chk("R5 reserved", {30'h0, dma_req_o, irq_o}, 32'h0);
      wr(8'h00, 32'h0000_0001);
      chk("R5 off", {30'h0, dma_req_o, irq_o}, 32'h0);

      // R3 / R4 soft reset
      rd_chk("R4 pre", 8'h08, 32'h09);
      wr(8'h00, 32'h0000_0600);
      chk("R3 pulse", 32'(soft_rst_o), 32'h1);
      rd_chk("R3 reads 0", 8'h00, 32'h0000_0200);
      @(negedge clk_i);
      chk("R3 one cycle", 32'(soft_rst_o), 32'h0);
      rd_chk("R4 disabled keeps", 8'h08, 32'h09);
      wr(8'h00, 32'h0000_0400);
      @(negedge clk_i);
      rd_chk("R4 cleared", 8'h08, 32'h0);

      // R8 / R10 set beats clear
      @(negedge clk_i);
      low_freq_set_i = 1'b1; wr_en_i = 1'b1; addr_i = 8'h08; wr_data_i = 32'h0001_0000;
      @(negedge clk_i);
      low_freq_set_i = 1'b0; wr_en_i = 1'b0;
      rd_chk("R8 set wins", 8'h08, 32'h0001_0000);
      chk("R10 err irq", 32'(err_irq_o), 32'h1);
      wr(8'h08, 32'h0001_0000);
      chk("R10 err irq clr", 32'(err_irq_o), 32'h0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule